// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned W-bit operands and a carry-in, producing a W-bit sum and a carry-out in purely combinational logic. Every bit position forms a generate term (both operand bits set) and a propagate term (operand bits differ). The sum bit is the propagate term XORed with the carry arriving at that position.

Carries are never rippled. The bits are split into nibble-wide groups. Each group resolves its three internal carries as flat sum-of-products expressions and reports a group generate and a group propagate. A second unit of the same form takes those group terms, together with the carry-in, and produces the carry into every group. When there are more than four groups, a third unit of the same form sits above the second. The carry-out is taken from the block-wide generate and propagate terms.

The block is meant for wide datapaths where the depth of a rippled carry is too great. The width W must be a multiple of 4 between 4 and 64.

Top module: `clah_adder`

## Requirements
- R1: For every input combination, the concatenation {cout_o, sum_o} equals a_i + b_i + cin_i as an unsigned (W+1)-bit value. This holds exhaustively at W = 8 and for random vectors at W = 16 and W = 32.
- R2: The carry entering nibble group k (bit 4k) equals bit 4k of the sum of the low 4k operand bits plus cin_i. At the ports this carry is visible as sum_o[4k] ^ a_i[4k] ^ b_i[4k].
- R3: When a group's four bits all propagate (a_i ^ b_i is 1111 over the group), the carry leaving that group equals the carry entering it.
- R4: When a group's operand nibbles alone sum to more than 15, that group emits a carry whatever the carry entering it.
- R5: cout_o equals the block generate OR (block propagate AND cin_i). For example, all-ones plus zero gives cout_o = cin_i, and all-ones plus all-ones gives cout_o = 1.
- R6: The block holds no state. Outputs settle to the result of the present inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bound checker is re-evaluated whenever the inputs change. On every evaluation it compares the full sum, every group carry, every group generate and propagate term, and the block-wide terms against arithmetic on the operands. What those comparisons cannot show is that the right structure is actually exercised. That comes only from the bench: the exhaustive 8-bit sweep, the carry-chain corners at 16 bits (a propagate group passing a carry through, a generating group that ignores its incoming carry, and all-ones operands), and the observation that outputs settle without any clock edge.

// File: rtl/clah_pkg.sv
package clah_pkg;
    localparam int GRP = 4;
    localparam int MAX_W = 64;

    function automatic int groups_of(input int n);
        return (n + GRP - 1) / GRP;
    endfunction
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i ^ b_i;
    end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
    input  logic [3:0] g_i,
    input  logic [3:0] p_i,
    input  logic       ci_i,
    output logic [3:0] c_o,
    output logic       gg_o,
    output logic       gp_o
);
    // flat two-level carries, no term depends on another carry
    always_comb begin
        c_o[0] = ci_i;
        c_o[1] = g_i[0] | (p_i[0] & ci_i);
        c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & ci_i);
        c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
               | (p_i[2] & p_i[1] & p_i[0] & ci_i);
        gg_o   = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
               | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
        gp_o   = &p_i;
    end
endmodule

// File: rtl/cla_sum_xor.sv
module cla_sum_xor #(
    parameter int W = 16
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    always_comb sum_o = prop_i ^ carry_i;
endmodule

// File: rtl/clah_adder.sv
module clah_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import clah_pkg::*;

    localparam int N1  = W / GRP;          // nibble groups
    localparam int N2  = groups_of(N1);    // second-level units
    localparam int N1P = N2 * GRP;         // padded group count

    logic [W-1:0]   bit_g, bit_p, bit_c;
    logic [N1-1:0]  grp_g, grp_p, grp_c;
    logic [N1P-1:0] g1_pad, p1_pad, c1_pad;
    logic [N2-1:0]  sg_g, sg_p, sg_c;
    logic           blk_g, blk_p;

    cla_pg_bits #(.W(W)) u_pg (
        .a_i   (a_i),
        .b_i   (b_i),
        .gen_o (bit_g),
        .prop_o(bit_p)
    );

    // first level: one unit per nibble
    for (genvar k = 0; k < N1; k++) begin : g_lvl1
        cla_lookahead4 u_la (
            .g_i (bit_g[GRP*k +: GRP]),
            .p_i (bit_p[GRP*k +: GRP]),
            .ci_i(grp_c[k]),
            .c_o (bit_c[GRP*k +: GRP]),
            .gg_o(grp_g[k]),
            .gp_o(grp_p[k])
        );
    end

    // pad unused group slots as pure pass-through (g=0, p=1)
    for (genvar j = 0; j < N1P; j++) begin : g_pad1
        if (j < N1) begin : g_real
            assign g1_pad[j] = grp_g[j];
            assign p1_pad[j] = grp_p[j];
        end else begin : g_fill
            assign g1_pad[j] = 1'b0;
            assign p1_pad[j] = 1'b1;
        end
    end

    // second level: carries into each group
    for (genvar m = 0; m < N2; m++) begin : g_lvl2
        cla_lookahead4 u_la (
            .g_i (g1_pad[GRP*m +: GRP]),
            .p_i (p1_pad[GRP*m +: GRP]),
            .ci_i(sg_c[m]),
            .c_o (c1_pad[GRP*m +: GRP]),
            .gg_o(sg_g[m]),
            .gp_o(sg_p[m])
        );
    end
    assign grp_c = c1_pad[N1-1:0];

    // third level only when more than one second-level unit exists
    if (N2 > 1) begin : g_lvl3
        logic [3:0] tg, tp, tc;
        for (genvar t = 0; t < GRP; t++) begin : g_pad3
            if (t < N2) begin : g_real
                assign tg[t] = sg_g[t];
                assign tp[t] = sg_p[t];
            end else begin : g_fill
                assign tg[t] = 1'b0;
                assign tp[t] = 1'b1;
            end
        end
        cla_lookahead4 u_la (
            .g_i (tg),
            .p_i (tp),
            .ci_i(cin_i),
            .c_o (tc),
            .gg_o(blk_g),
            .gp_o(blk_p)
        );
        assign sg_c = tc[N2-1:0];
    end else begin : g_no_lvl3
        assign sg_c[0] = cin_i;
        assign blk_g   = sg_g[0];
        assign blk_p   = sg_p[0];
    end

    cla_sum_xor #(.W(W)) u_sum (
        .prop_i (bit_p),
        .carry_i(bit_c),
        .sum_o  (sum_o)
    );

    assign cout_o = blk_g | (blk_p & cin_i);
endmodule

// File: rtl/clah_adder_chk.sv
module clah_adder_chk #(
    parameter int W = 16
) (
    input logic [W-1:0]     a_i,
    input logic [W-1:0]     b_i,
    input logic             cin_i,
    input logic [W-1:0]     sum_o,
    input logic             cout_o,
    input logic [W/4-1:0]   grp_c,
    input logic [W/4-1:0]   grp_g,
    input logic [W/4-1:0]   grp_p,
    input logic             blk_g,
    input logic             blk_p
);
    localparam int N1 = W / 4;

    function automatic logic carry_at(input int pos, input logic ci);
        logic [W:0] msk, lo;
        msk = ({{W{1'b0}}, 1'b1} << pos) - {{W{1'b0}}, 1'b1};
        lo  = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + {{W{1'b0}}, ci};
        return lo[pos];
    endfunction

    always_comb begin
        p_sum_exact_r1: assert ({cout_o, sum_o} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
            else $error("sum mismatch");
        p_block_prop_r5: assert (blk_p == (&(a_i ^ b_i)))
            else $error("block propagate mismatch");
        p_block_gen_r5: assert (blk_g ==
            (({1'b0, a_i} + {1'b0, b_i}) >> W))
            else $error("block generate mismatch");
        for (int k = 0; k < N1; k++) begin
            p_group_carry_r2: assert (grp_c[k] == carry_at(4 * k, cin_i))
                else $error("group carry mismatch");
            p_group_prop_r3: assert (grp_p[k] == (&(a_i[4*k +: 4] ^ b_i[4*k +: 4])))
                else $error("group propagate mismatch");
            p_group_gen_r4: assert (grp_g[k] ==
                (({1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]}) > 5'd15))
                else $error("group generate mismatch");
        end
    end
endmodule

bind clah_adder clah_adder_chk #(.W(W)) chk_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o),
    .grp_c (grp_c),
    .grp_g (grp_g),
    .grp_p (grp_p),
    .blk_g (blk_g),
    .blk_p (blk_p)
);

// File: tb/clah_adder_tb_top.sv
`timescale 1ns/1ps
module clah_adder_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0]  a8, b8, s8;
    logic [15:0] a16, b16, s16;
    logic [31:0] a32, b32, s32;
    logic        c8, c16, c32, co8, co16, co32;

    clah_adder #(.W(8)) dut_i (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
    clah_adder #(.W(16)) dut16_i (
        .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
    clah_adder #(.W(32)) dut32_i (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] add_ref(input logic [63:0] a, input logic [63:0] b,
                                            input logic ci, input int w);
        logic [63:0] msk;
        msk = (64'd1 << w) - 64'd1;
        return (a & msk) + (b & msk) + {63'd0, ci};
    endfunction

    // carry entering bit 4k, computed arithmetically
    function automatic logic carry_ref(input logic [63:0] a, input logic [63:0] b,
                                       input logic ci, input int k);
        logic [63:0] r;
        r = add_ref(a, b, ci, 4 * k);
        return r[4*k];
    endfunction

    task automatic chk16_groups(input string req);
        for (int k = 1; k < 4; k++)
            chk(req, {63'd0, s16[4*k] ^ a16[4*k] ^ b16[4*k]},
                {63'd0, carry_ref({48'd0, a16}, {48'd0, b16}, c16, k)});
    endtask

    task automatic corner16(input logic [15:0] a, input logic [15:0] b, input logic ci,
                            input logic [16:0] exp, input string req);
        @(posedge clk);
        a16 = a; b16 = b; c16 = ci;
        @(negedge clk);
        chk(req, {47'd0, co16, s16}, {47'd0, exp});
        chk16_groups(req);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 180000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<180000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        @(negedge clk);
        chk("R1 zero inputs", {55'd0, co8, s8}, 64'd0);
        chk("R1 zero inputs 32", {31'd0, co32, s32}, 64'd0);

        // R6: no clock edge between input change and observation
        @(negedge clk);
        a16 = 16'h1234; b16 = 16'h0FCC; c16 = 1'b1;
        #1;
        chk("R6 same-cycle settle", {47'd0, co16, s16}, 64'h2201);
        a16 = 16'hFFFF; b16 = 16'h0001; c16 = 1'b0;
        #0.5;
        chk("R6 same-cycle settle", {47'd0, co16, s16}, 64'h10000);

        // R3: group 1 all propagate, carry passes from group 1 into group 2
        corner16(16'h00FF, 16'h0001, 1'b0, 17'h00100, "R3 propagate pass");
        corner16(16'h00F0, 16'h0000, 1'b1, 17'h000F1, "R3 propagate no carry");
        // R4: group 1 generates regardless of its incoming carry
        corner16(16'h0080, 16'h0080, 1'b0, 17'h00100, "R4 generate cin0");
        corner16(16'h008F, 16'h0081, 1'b0, 17'h00110, "R4 generate cin1");
        // R5: block-level terms drive carry-out
        corner16(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R5 all propagate cin1");
        corner16(16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, "R5 all propagate cin0");
        corner16(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R5 all generate");
        corner16(16'h0000, 16'h0000, 1'b1, 17'h00001, "R5 no carry out");

        // R1 exhaustive at 8 bits; R1/R2 random at 16 and 32 bits alongside
        for (int v = 0; v < 131072; v++) begin
            @(posedge clk);
            a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
            a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
            a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
            @(negedge clk);
            chk("R1 w8", {55'd0, co8, s8}, add_ref({56'd0, a8}, {56'd0, b8}, c8, 8));
            chk("R2 w8 group1", {63'd0, s8[4] ^ a8[4] ^ b8[4]},
                {63'd0, carry_ref({56'd0, a8}, {56'd0, b8}, c8, 1)});
            if (v % 8 == 0) begin
                chk("R1 w16", {47'd0, co16, s16}, add_ref({48'd0, a16}, {48'd0, b16}, c16, 16));
                chk("R1 w32", {31'd0, co32, s32}, add_ref({32'd0, a32}, {32'd0, b32}, c32, 32));
                chk16_groups("R2 w16");
                for (int k = 1; k < 8; k++)
                    chk("R2 w32", {63'd0, s32[4*k] ^ a32[4*k] ^ b32[4*k]},
                        {63'd0, carry_ref({32'd0, a32}, {32'd0, b32}, c32, k)});
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule